// File: doc/BRIEF.md
# Per-Line Programmable Edge Watcher

The block watches a bank of up to 256 input lines and reports, one line at a time, when a line makes the kind of transition that software has chosen for it. Each line has its own 2-bit mode, which selects rising, falling or both edges, and its own 1-bit mask. The modes and masks are held in 32-bit words behind a small register port. Each word is written in one cycle and read back combinationally.

Every cycle the watcher registers the lines and keeps the sample from the cycle before. It compares the two samples, picks the edge kind that each line's mode asks for, removes the masked lines and registers the result as a one-cycle pulse vector. A single flag reports whether any line fired in that cycle. The lines are assumed to be synchronous to the block clock already.

Top module: `edge_watch_bank`

## Requirements
- R1: Reset is synchronous and active low. During reset and in the first cycle after it, `evt_o` and `evt_any_o` are 0. After reset all mode and mask words read 0. The sample registers load the live input during reset, so a nonzero bus held through reset produces no event.
- R2: Mode 2'b00 detects rising edges. If a line goes from 0 to 1 in the value driven before clock edge k, its `evt_o` bit is high for exactly one cycle after edge k+1.
- R3: Mode 2'b01 detects falling edges (1 to 0), with the same latency as R2. A rising edge on such a line produces no event.
- R4: Mode 2'b10 detects both edges. Both a 0-to-1 and a 1-to-0 change produce an event.
- R5: Mode 2'b11 is reserved. A line in this mode never produces an event.
- R6: A mask bit of 1 suppresses the events of its line and a mask bit of 0 lets them through. The mask and mode values that apply are those held when the event is registered.
- R7: The mode of line r is held in the control word at byte address 0x808 + 4*(r/16), in bits (r%16)*2+1 : (r%16)*2. There are 16 control words, 0x808 to 0x844.
- R8: The mask of line r is held in the mask word at byte address 0x848 + 4*(r/32), in bit r%32. There are 8 mask words, 0x848 to 0x864.
- R9: A read of a mapped, word-aligned address returns the last value written there, unchanged.
- R10: Writes to any other address are ignored, including addresses that are not word aligned. Reads from such addresses return 0.
- R11: `evt_any_o` is high exactly in the cycles in which at least one bit of `evt_o` is high.
- R12: Lines are independent. Any mix of changes across the bus gives, per line, the event that its own mode and mask dictate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lines_i | input | LINES | Monitored lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address for the write and the read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_o | output | LINES | One-cycle event pulse per line |
| evt_any_o | output | 1 | High when any event bit is high |

## Verification
The bench goes after several specific failure modes:
- The release from reset with a nonzero bus. A design that reset its previous-sample register to zero would report a spurious rising edge here.
- The top bit positions of the last control word and the last mask word. A design that decoded the field offset or the word index wrongly would move line 255's mode or mask onto another line.
- Misaligned writes and writes just past each range. A design that dropped the low address bits would corrupt control word 0.
- The reserved mode. A design that let it fall through to the toggle or rising decode would fire on it.
- The pulse width. A design that held an event level instead of pulsing would show up as a second high cycle.

// File: rtl/edge_watch_bank.sv
module edge_watch_bank #(
  parameter int          LINES    = 256,
  parameter logic [11:0] CTL_BASE = 12'h808,
  parameter logic [11:0] MSK_BASE = 12'h848
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_i,
  input  logic             reg_we,
  input  logic [11:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [LINES-1:0] evt_o,
  output logic             evt_any_o
);
  localparam int          CTL_WORDS = (LINES + 15) / 16;
  localparam int          MSK_WORDS = (LINES + 31) / 32;
  localparam logic [11:0] CTL_END   = 12'(int'(CTL_BASE) + 4 * CTL_WORDS);
  localparam logic [11:0] MSK_END   = 12'(int'(MSK_BASE) + 4 * MSK_WORDS);

  logic [31:0] ctl_q [CTL_WORDS];
  logic [31:0] msk_q [MSK_WORDS];
  logic [2*LINES-1:0] mode_flat;
  logic [LINES-1:0]   mask_flat;
  logic [LINES-1:0]   cur_q, prev_q, evt_q, hit;

  logic [11:0] ctl_off, msk_off;
  logic [9:0]  ctl_idx, msk_idx;
  logic        ctl_hit, msk_hit;

  assign ctl_off = reg_addr - CTL_BASE;
  assign msk_off = reg_addr - MSK_BASE;
  assign ctl_idx = ctl_off[11:2];
  assign msk_idx = msk_off[11:2];
  assign ctl_hit = (reg_addr >= CTL_BASE) && (reg_addr < CTL_END) && (reg_addr[1:0] == 2'b00);
  assign msk_hit = (reg_addr >= MSK_BASE) && (reg_addr < MSK_END) && (reg_addr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < CTL_WORDS; w++) ctl_q[w] <= '0;
      for (int w = 0; w < MSK_WORDS; w++) msk_q[w] <= '0;
    end else if (reg_we) begin
      for (int w = 0; w < CTL_WORDS; w++)
        if (ctl_hit && ctl_idx == 10'(w)) ctl_q[w] <= reg_wdata;
      for (int w = 0; w < MSK_WORDS; w++)
        if (msk_hit && msk_idx == 10'(w)) msk_q[w] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < CTL_WORDS; w++)
      if (ctl_hit && ctl_idx == 10'(w)) reg_rdata = ctl_q[w];
    for (int w = 0; w < MSK_WORDS; w++)
      if (msk_hit && msk_idx == 10'(w)) reg_rdata = msk_q[w];
  end

  for (genvar r = 0; r < LINES; r++) begin : g_line
    assign mode_flat[2*r +: 2] = ctl_q[r/16][(r%16)*2 +: 2];
    assign mask_flat[r]        = msk_q[r/32][r%32];
  end

  always_comb begin
    for (int r = 0; r < LINES; r++) begin
      case (mode_flat[2*r +: 2])
        2'b00:   hit[r] = ~prev_q[r] &  cur_q[r];
        2'b01:   hit[r] =  prev_q[r] & ~cur_q[r];
        2'b10:   hit[r] =  prev_q[r] ^  cur_q[r];
        default: hit[r] = 1'b0;
      endcase
      if (mask_flat[r]) hit[r] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= lines_i;
      prev_q <= lines_i;
      evt_q  <= '0;
    end else begin
      cur_q  <= lines_i;
      prev_q <= cur_q;
      evt_q  <= hit;
    end
  end

  assign evt_o     = evt_q;
  assign evt_any_o = |evt_q;
endmodule

// File: rtl/edge_watch_bank_chk.sv
module edge_watch_bank_chk #(
  parameter int LINES = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LINES-1:0]   lines_i,
  input logic [LINES-1:0]   evt_o,
  input logic               evt_any_o,
  input logic [2*LINES-1:0] mode_flat,
  input logic [LINES-1:0]   mask_flat
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd1) |-> (evt_o == '0 && !evt_any_o)); // R1

  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0) |-> ((evt_o & $past(mask_flat)) == '0)); // R6

  AST_EVT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> ((evt_o & ~($past(lines_i, 2) ^ $past(lines_i, 3))) == '0)); // R12

  AST_ANY_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && evt_any_o) |-> ($past(lines_i, 2) != $past(lines_i, 3))); // R11

  for (genvar r = 0; r < LINES; r++) begin : g_line
    AST_RISE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && evt_o[r] && $past(mode_flat[2*r +: 2]) == 2'b00) |-> $past(lines_i[r], 2)); // R2
    AST_FALL_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && evt_o[r] && $past(mode_flat[2*r +: 2]) == 2'b01) |-> !$past(lines_i[r], 2)); // R3
    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && evt_o[r]) |-> ($past(mode_flat[2*r +: 2]) != 2'b11)); // R5
  end
endmodule

bind edge_watch_bank edge_watch_bank_chk #(.LINES(LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lines_i   (lines_i),
  .evt_o     (evt_o),
  .evt_any_o (evt_any_o),
  .mode_flat (mode_flat),
  .mask_flat (mask_flat)
);

// File: tb/edge_watch_bank_test.sv
module edge_watch_bank_test;
  localparam int          N  = 256;
  localparam logic [11:0] CB = 12'h808;
  localparam logic [11:0] MB = 12'h848;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  lines_i = '0;
  logic          reg_we = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  evt_o;
  logic          evt_any_o;

  edge_watch_bank #(.LINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .lines_i(lines_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_o(evt_o), .evt_any_o(evt_any_o)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [N-1:0] ev;
    string        tag;
  } exp_t;

  exp_t         q[$];
  int           checks = 0;
  int           errors = 0;
  bit           mon_en = 1'b0;
  bit           done   = 1'b0;
  bit [1:0]     mmode [N];
  bit           mmask [N];
  logic [N-1:0] mprev;
  logic [N-1:0] vec;

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model(input logic [N-1:0] p, input logic [N-1:0] c);
    logic [N-1:0] e;
    for (int r = 0; r < N; r++) begin
      case (mmode[r])
        2'b00:   e[r] = ~p[r] & c[r];
        2'b01:   e[r] = p[r] & ~c[r];
        2'b10:   e[r] = p[r] ^ c[r];
        default: e[r] = 1'b0;
      endcase
      if (mmask[r]) e[r] = 1'b0;
    end
    return e;
  endfunction

  task automatic step(input logic [N-1:0] v, input string tag);
    exp_t it;
    lines_i = v;
    it.ev  = model(mprev, v);
    it.tag = tag;
    mprev  = v;
    q.push_back(it);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(mprev, tag);
    reg_we = 1'b0;
    if (a[1:0] == 2'b00 && a >= CB && a < CB + 12'd64)
      for (int j = 0; j < 16; j++) mmode[int'(a - CB) / 4 * 16 + j] = d[2*j +: 2];
    if (a[1:0] == 2'b00 && a >= MB && a < MB + 12'd32)
      for (int j = 0; j < 32; j++) mmask[int'(a - MB) / 4 * 32 + j] = d[j];
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    reg_addr = a;
    #2;
    chk(reg_rdata == e, tag, N'(reg_rdata), N'(e));
    step(mprev, tag);
  endtask

  function automatic logic [N-1:0] rnd();
    logic [N-1:0] v;
    for (int k = 0; k < N/32; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  always begin
    @(posedge clk);
    #1;
    if (mon_en && q.size() >= 2) begin
      exp_t it;
      it = q.pop_front();
      chk(evt_o == it.ev, it.tag, evt_o, it.ev);
      chk(evt_any_o == (|it.ev), "R11", N'(evt_any_o), N'(|it.ev));
    end
  end

  initial begin
    #(20ns * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < N; r++) begin mmode[r] = 2'b00; mmask[r] = 1'b0; end
    vec = {8{32'hA5C3_0F96}};
    lines_i = vec;
    mprev = vec;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(evt_o == '0 && !evt_any_o, "R1", evt_o, '0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    step(vec, "R1");
    step(vec, "R1");
    rd(CB, 32'h0, "R1");
    rd(MB, 32'h0, "R1");
    rd(CB + 12'h03C, 32'h0, "R1");

    step('0, "R2");
    step('1, "R2");
    step('1, "R2");

    wr(CB, 32'h0000_0400, "R3");
    step(~(N'(1) << 5), "R3");
    step('1, "R3");

    wr(CB + 12'h004, 32'hAAAA_AAAA, "R4");
    wr(CB + 12'h008, 32'hFFFF_FFFF, "R5");
    wr(CB + 12'h03C, 32'h4000_0000, "R7");
    step('0, "R4");
    step('1, "R4");
    step('0, "R7");

    wr(MB, 32'h0000_00F0, "R6");
    wr(MB + 12'h01C, 32'h8000_0000, "R8");
    step('1, "R6");
    step('0, "R8");
    wr(MB, 32'h0, "R6");
    step('1, "R6");
    step('0, "R6");

    rd(CB + 12'h004, 32'hAAAA_AAAA, "R9");
    rd(CB + 12'h03C, 32'h4000_0000, "R9");
    rd(MB + 12'h01C, 32'h8000_0000, "R9");
    rd(CB, 32'h0000_0400, "R9");

    wr(MB + 12'h020, 32'hFFFF_FFFF, "R10");
    wr(CB + 12'h002, 32'hFFFF_FFFF, "R10");
    wr(CB - 12'h004, 32'hFFFF_FFFF, "R10");
    wr(12'h000, 32'hFFFF_FFFF, "R10");
    rd(MB + 12'h020, 32'h0, "R10");
    rd(CB + 12'h002, 32'h0, "R10");
    rd(CB - 12'h004, 32'h0, "R10");
    rd(CB, 32'h0000_0400, "R10");
    rd(MB, 32'h0, "R10");
    step('1, "R10");
    step('0, "R10");

    for (int w = 0; w < 16; w++) wr(CB + 12'(4 * w), $urandom, "R12");
    for (int w = 0; w < 8; w++) wr(MB + 12'(4 * w), $urandom & $urandom, "R12");
    for (int i = 0; i < 300; i++) step(rnd(), "R12");
    step(mprev, "R12");
    step(mprev, "R12");
    step(mprev, "R12");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule